// File: doc/BRIEF.md
# Interleaved Two-Channel Converter Data Driver

This block feeds one digital-to-analog converter that has a single data port wired and is therefore run in interleaved mode. Two signed sample streams arrive in the fabric clock domain, one stream per analog output. The block recodes each sample from two's complement to offset binary and alternates the two channels on the shared data bus. A select line tells the converter which channel the current word belongs to, and a converter clock is derived from the fabric clock. Each of these outputs comes straight from a flop.

Every word stays on the bus for `WORD_HOLD` fabric cycles, which must be an even number of at least two. The converter clock is low during the first half of each word and high during the second half. Its rising edge therefore lands in the middle of a stable word. A synchronous, active-high reset may be a single-cycle pulse. While it is active the bus is parked at mid-scale, and the next word after release always belongs to channel A.

Top module: `dacil_drv`

## Requirements
- R1: While reset is high at a clock edge, the outputs after that edge are: data bus at mid-scale (0x200 for 10-bit samples, in general 2^(DATA_W-1)), select at 0, and converter clock low.
- R2: Each word on the bus equals the signed input sample plus 2^(DATA_W-1), which is the sample with its top bit inverted. For 10-bit samples, -512 gives 0x000, 0 gives 0x200 and +511 gives 0x3FF.
- R3: The first clock edge after reset is released loads a word. That word carries the channel A input present at that edge, and select is 0. Input-to-bus latency is one register stage.
- R4: Words alternate between the channels in the order A, B, A, B. Select is 0 while a channel A word is on the bus and 1 while a channel B word is on the bus. Select changes only in the cycle in which a new word is loaded.
- R5: Each word and its select value stay unchanged for WORD_HOLD cycles. Input changes during the cycles between loads have no effect on the bus.
- R6: The converter clock is low for the first WORD_HOLD/2 cycles of each word and high for the remaining WORD_HOLD/2 cycles.
- R7: A single-cycle reset pulse in the middle of a stream forces mid-scale output on the next cycle. The stream then restarts with a channel A word on the following edge, whatever channel had been due next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset, may be a one-cycle pulse |
| ch_a_i | input | DATA_W | Channel A sample, two's complement |
| ch_b_i | input | DATA_W | Channel B sample, two's complement |
| dac_data_o | output | DATA_W | Shared converter data bus, offset binary |
| dac_sel_o | output | 1 | Channel marker for the word on the bus (0 = A, 1 = B) |
| dac_clk_o | output | 1 | Converter clock, rising in the middle of each word |

## Verification
The bench builds the block with DATA_W = 10 and WORD_HOLD = 4. With a four-cycle word, the two-low, two-high pattern of the converter clock becomes visible. There are also three input cycles per word in which changes must be ignored. The 10-bit width places the conversion extremes at the exact codes 0x000, 0x200 and 0x3FF. Inputs change on every cycle, so any stray load or mis-timed load changes the bus and is caught.

// File: rtl/dacil_pkg.sv
package dacil_pkg;

    // Channel identity carried on the select line.
    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } dac_ch_e;

    // Order of service: A then B then A ...
    function automatic dac_ch_e dacil_next_ch(input dac_ch_e cur);
        return (cur == CH_A) ? CH_B : CH_A;
    endfunction

    // Position counter width for a word hold length.
    function automatic int dacil_pos_w(input int hold);
        return (hold > 2) ? $clog2(hold) : 1;
    endfunction

endpackage

// File: rtl/dacil_fmt.sv
// Signed to offset-binary recoding for one channel.
module dacil_fmt #(
    parameter int DATA_W = 10
) (
    input  logic [DATA_W-1:0] sgn_i,
    output logic [DATA_W-1:0] off_o
);
    localparam logic [DATA_W-1:0] TOP_BIT = DATA_W'(1) << (DATA_W - 1);

    always_comb begin
        off_o = sgn_i ^ TOP_BIT;
    end

    // R2: negative samples map below mid-scale, non-negative at or above.
    always_comb begin
        if (!$isunknown(sgn_i)) begin
            assert_fmt_order_R2: assert ($signed(sgn_i) < 0 ? (off_o < TOP_BIT) : (off_o >= TOP_BIT))
                else $error("offset recoding out of order");
        end
    end
endmodule

// File: rtl/dacil_seq.sv
// Word sequencer: slot position, next channel and converter clock phase.
module dacil_seq
    import dacil_pkg::*;
#(
    parameter int WORD_HOLD = 2
) (
    input  logic    clk,
    input  logic    rst,
    output logic    ld_o,
    output dac_ch_e ld_ch_o,
    output logic    dclk_nxt_o
);
    localparam int PW = dacil_pos_w(WORD_HOLD);
    localparam logic [PW-1:0] LAST = PW'(WORD_HOLD - 1);
    localparam logic [PW-1:0] HALF = PW'(WORD_HOLD / 2);

    logic [PW-1:0] pos_q, pos_d;
    dac_ch_e       ch_q;

    initial begin
        assert_hold_even_R6: assert (WORD_HOLD >= 2 && (WORD_HOLD % 2) == 0)
            else $error("WORD_HOLD must be even and at least 2");
    end

    always_comb begin
        ld_o       = (pos_q == LAST);
        pos_d      = ld_o ? '0 : pos_q + PW'(1);
        ld_ch_o    = ch_q;
        dclk_nxt_o = !rst && (pos_d >= HALF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= LAST;
            ch_q  <= CH_A;
        end else begin
            pos_q <= pos_d;
            if (ld_o) begin
                ch_q <= dacil_next_ch(ch_q);
            end
        end
    end
endmodule

// File: rtl/dacil_outreg.sv
// Output register: data, select and converter clock leave from flops together.
module dacil_outreg
    import dacil_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  dac_ch_e           ld_ch_i,
    input  logic              dclk_nxt_i,
    input  logic [DATA_W-1:0] word_a_i,
    input  logic [DATA_W-1:0] word_b_i,
    output logic [DATA_W-1:0] data_o,
    output dac_ch_e           sel_o,
    output logic              dclk_o
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        dac_ch_e           sel;
        logic              dclk;
    } port_word_t;

    port_word_t q, d;

    always_comb begin
        d      = q;
        d.dclk = dclk_nxt_i;
        if (ld_i) begin
            d.sel  = ld_ch_i;
            d.data = (ld_ch_i == CH_A) ? word_a_i : word_b_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.data <= MID;
            q.sel  <= CH_A;
            q.dclk <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data_o = q.data;
    assign sel_o  = q.sel;
    assign dclk_o = q.dclk;

    // R5: no load means the word and its marker stay put.
    assert_word_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !ld_i |=> ($stable(data_o) && $stable(sel_o)))
        else $error("bus changed without a load");

    // R6: every new word starts in the low half of the converter clock.
    assert_clk_low_on_load_R6: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> !dclk_o)
        else $error("converter clock high at word start");
endmodule

// File: rtl/dacil_drv.sv
// Top: two signed streams onto one interleaved converter port.
module dacil_drv
    import dacil_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int WORD_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ch_a_i,
    input  logic [DATA_W-1:0] ch_b_i,
    output logic [DATA_W-1:0] dac_data_o,
    output logic              dac_sel_o,
    output logic              dac_clk_o
);
    localparam int                NCH = 2;
    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    logic [DATA_W-1:0] raw  [NCH];
    logic [DATA_W-1:0] conv [NCH];
    logic              ld;
    dac_ch_e           ld_ch;
    dac_ch_e           sel;
    logic              dclk_nxt;

    assign raw[0] = ch_a_i;
    assign raw[1] = ch_b_i;

    for (genvar g = 0; g < NCH; g++) begin : g_fmt
        dacil_fmt #(.DATA_W(DATA_W)) u_fmt (
            .sgn_i (raw[g]),
            .off_o (conv[g])
        );
    end

    dacil_seq #(.WORD_HOLD(WORD_HOLD)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ld_o       (ld),
        .ld_ch_o    (ld_ch),
        .dclk_nxt_o (dclk_nxt)
    );

    dacil_outreg #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .ld_i       (ld),
        .ld_ch_i    (ld_ch),
        .dclk_nxt_i (dclk_nxt),
        .word_a_i   (conv[0]),
        .word_b_i   (conv[1]),
        .data_o     (dac_data_o),
        .sel_o      (sel),
        .dclk_o     (dac_clk_o)
    );

    assign dac_sel_o = sel;

    // R1 / R7: a reset edge parks the port at mid-scale on channel A.
    assert_reset_park_R1: assert property (@(posedge clk)
        rst |=> (dac_data_o == MID && dac_sel_o == 1'b0 && !dac_clk_o))
        else $error("port not parked after reset");

    // R4: the channel marker moves only on a load.
    assert_sel_on_load_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_sel_o) |-> $past(ld))
        else $error("select moved between loads");
endmodule

// File: tb/dacil_drv_bench.sv
module dacil_drv_bench;
    localparam int W    = 10;
    localparam int HOLD = 4;
    localparam logic [W-1:0] MIDV = W'(1) << (W - 1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] ch_a = '0;
    logic [W-1:0] ch_b = '0;
    logic [W-1:0] dac_data;
    logic         dac_sel;
    logic         dac_clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural model state.
    int           m_pos;
    int           m_nxt;
    logic [W-1:0] e_data;
    logic         e_sel;
    logic         e_clk;
    bit           e_load;
    bit           e_first;

    always #5 clk = ~clk;

    dacil_drv #(.DATA_W(W), .WORD_HOLD(HOLD)) u_dacil_drv (
        .clk        (clk),
        .rst        (rst),
        .ch_a_i     (ch_a),
        .ch_b_i     (ch_b),
        .dac_data_o (dac_data),
        .dac_sel_o  (dac_sel),
        .dac_clk_o  (dac_clk)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drive inputs, predict the port after the next rising edge,
    // wait for the next falling edge and compare.
    task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string ctx);
        rst  = r;
        ch_a = a;
        ch_b = b;
        e_load  = 0;
        e_first = 0;
        if (r) begin
            m_pos  = HOLD - 1;
            m_nxt  = 0;
            e_data = MIDV;
            e_sel  = 1'b0;
            e_clk  = 1'b0;
        end else begin
            if (m_pos == HOLD - 1) begin
                e_first = (e_sel == 1'b0) && (e_data == MIDV) && (m_nxt == 0) && !e_clk;
                e_data  = ((m_nxt == 1) ? b : a) ^ MIDV;
                e_sel   = (m_nxt == 1);
                m_pos   = 0;
                m_nxt   = 1 - m_nxt;
                e_load  = 1;
            end else begin
                m_pos++;
            end
            e_clk = (m_pos >= HOLD / 2);
        end
        @(negedge clk);
        if (r) begin
            chk({"R1 data ", ctx}, dac_data, e_data);
            chk({"R1 sel ", ctx},  dac_sel,  e_sel);
            chk({"R1 clk ", ctx},  dac_clk,  e_clk);
        end else begin
            chk(e_load ? {"R2 R3 data ", ctx} : {"R5 data ", ctx}, dac_data, e_data);
            chk(e_load ? {"R4 sel ", ctx} : {"R5 sel ", ctx},      dac_sel,  e_sel);
            chk({"R6 clk ", ctx}, dac_clk, e_clk);
        end
    endtask

    initial begin
        m_pos  = HOLD - 1;
        m_nxt  = 0;
        e_data = MIDV;
        e_sel  = 0;
        e_clk  = 0;
        @(negedge clk);
        // R1: held reset with moving inputs
        for (int i = 0; i < 3; i++) step(1'b1, W'(i * 77), W'(i * 131), "reset");
        // R3: first word after release is channel A with one stage of latency
        step(1'b0, 10'h155, 10'h0AA, "first");
        chk("R3 first word channel A", dac_sel, 0);
        chk("R3 first word value", dac_data, 10'h155 ^ MIDV);
        // R4 R5 R6: streaming with inputs changing every cycle
        for (int i = 0; i < 120; i++) step(1'b0, W'($urandom), W'($urandom), "stream");
        // R2: conversion extremes; hold them through full words on both channels
        for (int i = 0; i < 2 * HOLD; i++) step(1'b0, 10'h200, 10'h1FF, "extreme");
        for (int i = 0; i < 2 * HOLD; i++) step(1'b0, 10'h000, 10'h3FF, "extreme");
        chk("R2 zero maps to mid-scale",
            int'(10'h000 ^ MIDV), 10'h200);
        // R7: single-cycle reset pulse in mid-word, then restart at channel A
        step(1'b0, 10'h011, 10'h022, "pre-pulse");
        step(1'b1, 10'h033, 10'h044, "R7 pulse");
        chk("R7 mid-scale after pulse", dac_data, MIDV);
        step(1'b0, 10'h2F0, 10'h0F0, "R7 restart");
        chk("R7 restart on channel A", dac_sel, 0);
        chk("R7 restart value", dac_data, 10'h2F0 ^ MIDV);
        for (int i = 0; i < 40; i++) step(1'b0, W'($urandom), W'($urandom), "tail");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule